// File: doc/BRIEF.md
# Debug trace capture controller

This block runs one debug capture session at a time and keeps its results in a small trace store of eight 16-bit entries. Software starts a session with an arm command. From then on the block either records the target addresses of program-flow changes or, when an event-only mode is selected, records the bus data byte each time a trigger event fires. Deciding when a trigger happens is done elsewhere: the block only sees a one-cycle trigger pulse and two comparator hit pulses.

A session ends in one of three ways. In a begin-type session, recording starts at the trigger and the session closes as soon as the store fills. In an end-type session, recording runs from the arm onwards as a ring that drops the oldest entry when full, and the trigger closes it. A write of zero to the arm control, or dropping the module enable, closes any session at once. Event-only sessions are always begin-type, whatever the begin/end select says. Once the session is closed, the store is read out oldest-first through a pop port.

Top module: `trace_capture_ctrl`

## Requirements
- R1: When `arm_wr` is high with `arm_val` = 1 and `en` = 1, on the next clock `armed` is 1, `a_seen` and `b_seen` are 0 and `count` is 0; any other input in that cycle has no effect.
- R2: While a session runs, a pulse on `hit_a` (`hit_b`) sets `a_seen` (`b_seen`); the flags stay set after the session ends, until the next arm command.
- R3: With `evt_mode` = 0 and `end_sel` = 0 (begin-type), `cof_addr` is stored for each `cof_valid` from the trigger cycle onward (a change of flow in the trigger cycle is stored) and none before it; the push that brings `count` to 8 clears `armed` on the same clock.
- R4: With `evt_mode` = 0 and `end_sel` = 1 (end-type), `cof_addr` is stored for every `cof_valid` from the arm onwards; when the store holds 8 entries a new one replaces the oldest and `count` stays 8; a trigger clears `armed` on the next clock, and a change of flow in the trigger cycle is still stored.
- R5: With `evt_mode` = 1, each trigger stores {8'h00, `bus_data`}, `cof_valid` stores nothing, `end_sel` has no effect, and the push that brings `count` to 8 clears `armed`.
- R6: During a session, `arm_wr` with `arm_val` = 0, or `en` = 0, clears `armed` on the next clock and leaves the stored entries and `count` unchanged.
- R7: While `en` = 0 an arm command is ignored: `armed` stays 0 and `count` is unchanged.
- R8: While `armed` = 0 and `count` > 0, `rd_data` shows the oldest entry and a `rd_pop` pulse removes it and lowers `count` by one; `rd_pop` while armed or while `count` = 0 has no effect.
- R9: `count` never exceeds 8.
- R10: After reset `armed`, `a_seen`, `b_seen` and `count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; low stops and blocks sessions |
| arm_wr | input | 1 | Write strobe for the arm control |
| arm_val | input | 1 | Value written to the arm control |
| end_sel | input | 1 | 1 selects end-type, 0 begin-type recording |
| evt_mode | input | 1 | 1 when an event-only trigger mode is selected |
| trig | input | 1 | Trigger event pulse |
| hit_a | input | 1 | Comparator A hit pulse |
| hit_b | input | 1 | Comparator B hit pulse |
| cof_valid | input | 1 | A change of program flow happens this cycle |
| cof_addr | input | 16 | Destination address of that change of flow |
| bus_data | input | 8 | Bus data byte of the current cycle |
| rd_pop | input | 1 | Pop the oldest stored entry |
| armed | output | 1 | Session running |
| a_seen | output | 1 | Comparator A hit during the session |
| b_seen | output | 1 | Comparator B hit during the session |
| count | output | 4 | Number of stored entries, 0 to 8 |
| rd_data | output | 16 | Oldest stored entry |

## Verification
The assertions watch, on every cycle, the arm clearing, the one-cycle stop on a manual write or lost enable, the close on trigger for end-type and on the filling push for begin-type sessions, the sticky comparator flags, the count bound, the hold at 8 while the ring overwrites, and that no pop reaches an empty or running store. What was actually stored, in which order, which entry the ring dropped and that event-only sessions keep the data byte rather than the address can only be shown by the bench, which reads the store out after each session and compares it with its own model.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int ENTRY_W = 16;
    localparam int BYTE_W  = 8;

    // one request to the trace store
    typedef struct packed {
        logic               valid;
        logic [ENTRY_W-1:0] data;
    } push_t;

    // what the session records, chosen from the mode inputs
    typedef enum logic [1:0] {
        REC_FLOW_BEGIN = 2'd0,
        REC_FLOW_END   = 2'd1,
        REC_EVT_DATA   = 2'd2
    } rec_kind_e;

    function automatic rec_kind_e rec_kind(input logic evt, input logic end_type);
        if (evt)           return REC_EVT_DATA;
        else if (end_type) return REC_FLOW_END;
        else               return REC_FLOW_BEGIN;
    endfunction

    // event-only sessions always close on a full store
    function automatic logic closes_on_full(input rec_kind_e k);
        return (k != REC_FLOW_END);
    endfunction

endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [W-1:0]  rdata
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          full;

    assign full  = (count == CW'(DEPTH));
    assign rdata = mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clr && !rst) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (push) begin
            wp <= nxt(wp);
            if (full) rp <= nxt(rp);       // ring: drop the oldest
            else      count <= count + 1'b1;
        end else if (pop) begin
            rp    <= nxt(rp);
            count <= count - 1'b1;
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0) && !push);

    p_ring_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (push && !clr && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/trace_run_ctrl.sv
module trace_run_ctrl
    import trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                arm_wr,
    input  logic                arm_val,
    input  logic                end_sel,
    input  logic                evt_mode,
    input  logic                trig,
    input  logic                hit_a,
    input  logic                hit_b,
    input  logic                cof_valid,
    input  logic [ENTRY_W-1:0]  cof_addr,
    input  logic [BYTE_W-1:0]   bus_data,
    input  logic                rd_pop,
    input  logic [CW-1:0]       count,
    output logic                armed,
    output logic                a_seen,
    output logic                b_seen,
    output logic                fifo_clr,
    output push_t               req,
    output logic                pop
);

    rec_kind_e kind;
    logic      arm_go, run, trg_seen, fill_end, trig_end;
    push_t     cap;

    assign kind   = rec_kind(evt_mode, end_sel);
    assign arm_go = en && arm_wr && arm_val;
    assign run    = armed && en && !arm_wr;

    always_comb begin
        cap = '0;
        unique case (kind)
            REC_EVT_DATA: begin
                cap.valid = trig;
                cap.data  = {{(ENTRY_W-BYTE_W){1'b0}}, bus_data};
            end
            REC_FLOW_END: begin
                cap.valid = cof_valid;
                cap.data  = cof_addr;
            end
            default: begin
                cap.valid = cof_valid && (trg_seen || trig);
                cap.data  = cof_addr;
            end
        endcase
        req       = cap;
        req.valid = run && cap.valid;
    end

    assign fill_end = req.valid && closes_on_full(kind) && (count == CW'(DEPTH - 1));
    assign trig_end = run && (kind == REC_FLOW_END) && trig;
    assign fifo_clr = arm_go;
    assign pop      = rd_pop && !armed && !arm_go && (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            a_seen   <= 1'b0;
            b_seen   <= 1'b0;
            trg_seen <= 1'b0;
        end else if (arm_go) begin
            armed    <= 1'b1;
            a_seen   <= 1'b0;
            b_seen   <= 1'b0;
            trg_seen <= 1'b0;
        end else if (armed) begin
            if (!run) begin
                armed <= 1'b0;
            end else begin
                if (hit_a) a_seen   <= 1'b1;
                if (hit_b) b_seen   <= 1'b1;
                if (trig)  trg_seen <= 1'b1;
                if (fill_end || trig_end) armed <= 1'b0;
            end
        end
    end

    p_arm_clears_r1: assert property (@(posedge clk) disable iff (rst)
        (en && arm_wr && arm_val) |=> armed && !a_seen && !b_seen && (count == '0));

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ((a_seen || b_seen) && !(en && arm_wr && arm_val))
        |=> (a_seen || !$past(a_seen)) && (b_seen || !$past(b_seen)));

    p_begin_full_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && en && !arm_wr && (evt_mode || !end_sel) && req.valid
         && count == CW'(DEPTH - 1)) |=> !armed && (count == CW'(DEPTH)));

    p_end_trig_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && en && !arm_wr && !evt_mode && end_sel && trig) |=> !armed);

    p_evt_no_flow_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_mode && !trig) |-> !req.valid);

    p_manual_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && (!en || (arm_wr && !arm_val))) |=> !armed && $stable(count));

    p_en_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (!armed && !en) |=> !armed);

    p_pop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !armed && !req.valid);

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                arm_wr,
    input  logic                arm_val,
    input  logic                end_sel,
    input  logic                evt_mode,
    input  logic                trig,
    input  logic                hit_a,
    input  logic                hit_b,
    input  logic                cof_valid,
    input  logic [ENTRY_W-1:0]  cof_addr,
    input  logic [BYTE_W-1:0]   bus_data,
    input  logic                rd_pop,
    output logic                armed,
    output logic                a_seen,
    output logic                b_seen,
    output logic [CW-1:0]       count,
    output logic [ENTRY_W-1:0]  rd_data
);

    push_t req;
    logic  fifo_clr, pop;

    trace_run_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .en(en), .arm_wr(arm_wr), .arm_val(arm_val),
        .end_sel(end_sel), .evt_mode(evt_mode), .trig(trig),
        .hit_a(hit_a), .hit_b(hit_b), .cof_valid(cof_valid),
        .cof_addr(cof_addr), .bus_data(bus_data), .rd_pop(rd_pop),
        .count(count), .armed(armed), .a_seen(a_seen), .b_seen(b_seen),
        .fifo_clr(fifo_clr), .req(req), .pop(pop)
    );

    trace_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(fifo_clr), .push(req.valid),
        .wdata(req.data), .pop(pop), .count(count), .rdata(rd_data)
    );

    p_reset_state_r10: assert property (@(posedge clk)
        $past(rst) |-> !armed && !a_seen && !b_seen && (count == '0));

endmodule

// File: tb/sim_trace_capture_ctrl.sv
`timescale 1ns/1ps
module sim_trace_capture_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, arm_wr = 1'b0, arm_val = 1'b0, end_sel = 1'b0, evt_mode = 1'b0;
    logic        trig = 1'b0, hit_a = 1'b0, hit_b = 1'b0, cof_valid = 1'b0, rd_pop = 1'b0;
    logic [15:0] cof_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        armed, a_seen, b_seen;
    logic [3:0]  count;
    logic [15:0] rd_data;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    bit          m_armed, m_a, m_b, m_trg;
    logic [15:0] q[$];

    always #4 clk = ~clk;

    trace_capture_ctrl u0 (
        .clk(clk), .rst(rst), .en(en), .arm_wr(arm_wr), .arm_val(arm_val),
        .end_sel(end_sel), .evt_mode(evt_mode), .trig(trig), .hit_a(hit_a),
        .hit_b(hit_b), .cof_valid(cof_valid), .cof_addr(cof_addr),
        .bus_data(bus_data), .rd_pop(rd_pop), .armed(armed), .a_seen(a_seen),
        .b_seen(b_seen), .count(count), .rd_data(rd_data)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void mpush(logic [15:0] d);
        if (q.size() == 8) void'(q.pop_front());
        q.push_back(d);
    endfunction

    function automatic void model_clock();
        if (en && arm_wr && arm_val) begin
            m_armed = 1; m_a = 0; m_b = 0; m_trg = 0; q.delete();
        end else if (!m_armed) begin
            if (rd_pop && q.size() > 0) void'(q.pop_front());
        end else if (!en || arm_wr) begin
            m_armed = 0;
        end else begin
            if (hit_a) m_a = 1;
            if (hit_b) m_b = 1;
            if (evt_mode) begin
                if (trig) mpush({8'h00, bus_data});
            end else if (end_sel) begin
                if (cof_valid) mpush(cof_addr);
                if (trig) m_armed = 0;
            end else begin
                if (trig) m_trg = 1;
                if (m_trg && cof_valid) mpush(cof_addr);
            end
            if ((evt_mode || !end_sel) && q.size() == 8) m_armed = 0;
        end
    endfunction

    task automatic compare(string tag);
        check(tag, "armed", armed, m_armed);
        check(tag, "a_seen", a_seen, m_a);
        check(tag, "b_seen", b_seen, m_b);
        check(tag, "count", count, q.size());
        if (!m_armed && q.size() > 0) check(tag, "rd_data", rd_data, q[0]);
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare(tag);
        arm_wr = 0; trig = 0; hit_a = 0; hit_b = 0; cof_valid = 0; rd_pop = 0;
    endtask

    task automatic arm(bit ev, bit es, string tag);
        evt_mode = ev; end_sel = es; en = 1; arm_wr = 1; arm_val = 1;
        step(tag);
    endtask

    task automatic flow(logic [15:0] a, bit t, string tag);
        cof_valid = 1; cof_addr = a; trig = t;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        @(negedge clk); @(negedge clk);
        rst = 0;
        step("R10");
        check("R10", "reset count", count, 0);

        // R7: arm blocked while disabled
        en = 0; arm_wr = 1; arm_val = 1; step("R7");
        check("R7", "armed stays low", armed, 0);

        // R1 / R2
        arm(0, 0, "R1");
        check("R1", "armed", armed, 1);
        hit_a = 1; step("R2");
        check("R2", "a_seen set", a_seen, 1);

        // R3: begin-type, flow before the trigger is not stored
        flow(16'h0AA0, 0, "R3");
        flow(16'h0AA1, 0, "R3");
        flow(16'h1000, 1, "R3");
        for (int i = 1; i < 8; i++) flow(16'h1000 + 16'(i), 0, "R3");
        check("R3", "closed on full", armed, 0);
        check("R3", "count full", count, 8);
        check("R3", "first entry is trigger cycle", rd_data, 16'h1000);
        check("R2", "flag kept after close", a_seen, 1);
        rd_pop = 1; step("R8");
        check("R8", "count after pop", count, 7);
        check("R8", "next entry", rd_data, 16'h1001);

        // R4: end-type ring, trigger closes
        arm(0, 1, "R4");
        for (int i = 0; i < 11; i++) flow(16'h0100 + 16'(i), 0, "R4");
        check("R4", "count holds", count, 8);
        check("R4", "still armed", armed, 1);
        rd_pop = 1; step("R8");
        check("R8", "pop while armed ignored", count, 8);
        flow(16'h010B, 1, "R4");
        check("R4", "closed by trigger", armed, 0);
        check("R4", "oldest survivor", rd_data, 16'h0104);

        // R5: event-only, begin/end select ignored
        arm(1, 1, "R5");
        for (int i = 0; i < 8; i++) begin
            cof_valid = 1; cof_addr = 16'hBEEF; trig = 1; bus_data = 8'hC0 + 8'(i);
            step("R5");
            cof_valid = 1; cof_addr = 16'hBEEF; step("R5");
        end
        check("R5", "closed on full", armed, 0);
        check("R5", "data byte stored", rd_data, 16'h00C0);

        // R6: manual stop by arm write of zero, then by enable low
        arm(0, 1, "R6");
        for (int i = 0; i < 3; i++) flow(16'h2000 + 16'(i), 0, "R6");
        arm_wr = 1; arm_val = 0; step("R6");
        check("R6", "stopped", armed, 0);
        check("R6", "entries kept", count, 3);
        arm(0, 1, "R6");
        flow(16'h3000, 0, "R6");
        en = 0; step("R6");
        check("R6", "stopped by enable", armed, 0);
        check("R6", "entry kept", rd_data, 16'h3000);
        en = 1;
        rd_pop = 1; step("R8");
        rd_pop = 1; step("R8");
        check("R8", "pop on empty ignored", count, 0);

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            en        = ($urandom_range(0, 63) != 0);
            arm_wr    = ($urandom_range(0, 39) == 0);
            arm_val   = ($urandom_range(0, 3) != 0);
            if (arm_wr && arm_val) begin
                evt_mode = ($urandom_range(0, 2) == 0);
                end_sel  = $urandom_range(0, 1);
            end
            trig      = ($urandom_range(0, 11) == 0);
            hit_a     = ($urandom_range(0, 15) == 0);
            hit_b     = ($urandom_range(0, 15) == 0);
            cof_valid = $urandom_range(0, 1);
            cof_addr  = 16'($urandom);
            bus_data  = 8'($urandom);
            rd_pop    = ($urandom_range(0, 2) == 0);
            step("R9");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule